// File: doc/BRIEF.md
# Clock Divider Setting Solver

This block is a sequential calculator for a clock tree with four selectable sources behind a two-stage divider. Given a requested output frequency and the present frequency of each candidate source, it works out the divider settings for every valid source. It then reports the source whose divided output is the fastest one that does not exceed the request. All frequencies are 32-bit unsigned integers, and all arithmetic is integer.

Each source needs a total division ratio: the ceiling of the source frequency over the request, with the request first clamped down to the source frequency. A plain source is divided only by the post-divider. The last source, index 3, also has a pre-divider. On that source, any ratio above the post-divider range is split between the two stages by fixed ratio bands. The divisions run one at a time on a single bit-serial restoring divider. A full sweep of four sources takes roughly four hundred cycles.

Software or a power-management sequencer loads the request and source frequencies, pulses `start`, and waits for `done`. It then copies the source index and the two divider codes into the clock control register. It can also read back the frequency it will get.

Top module: `divsel_solver`

## Requirements
- R1: A start with a target of zero gives `done` one cycle later with `err` = 1 and `sel_src`, `pre_code`, `post_code` and `rate_out` all zero.
- R2: When the target is above a nonzero source frequency, that source is solved against its own frequency, giving ratio 1, both codes 0 and `rate_out` equal to the source frequency.
- R3: The ratio is ceil(source / target). For sources 0 to 2, and for source 3 when the ratio is 4 or less, the pre-divider is 1 (`pre_code` 0) and the post-divider equals the ratio (`post_code` = ratio - 1).
- R4: For source 3 with a ratio above 4, the split depends on the ratio. Below 32 the pre-divider is the ratio and the post-divider is 1. From 32 to 63 the post-divider is 2 and the pre-divider is ceil(ratio/2). From 64 to 95 they are 3 and ceil(ratio/3). From 96 up they are 4 and ceil(ratio/4). The codes are each value minus one: `pre_code` in 5 bits, `post_code` in 2 bits.
- R5: The post-divider saturates at 4 and the pre-divider at 32. A source whose saturated result is still above the target does not qualify.
- R6: The achieved frequency is floor(floor(source / pre) / post), and it is reported on `rate_out` for the chosen source.
- R7: Among sources whose `src_valid` bit is 1 and whose frequency is nonzero, the block picks the one with the largest achieved frequency that is at most the target and above zero. On equal results the lowest index wins.
- R8: When no source qualifies, `err` is 1 and `sel_src`, `pre_code`, `post_code` and `rate_out` are zero.
- R9: `done` is high for exactly one cycle per computation. The result outputs change only in the cycle where `done` is high, and hold otherwise.
- R10: A `start` pulse that arrives while a computation is running has no effect. The running computation finishes with its own result and no extra `done`.
- R11: After reset, `done`, `err` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation (accepted only when idle) |
| target | input | 32 | Requested output frequency, captured at start |
| src_freq | input | 4x32 | Frequency of each source, index 0 in the low word |
| src_valid | input | 4 | One bit per source; 1 lets that source compete (captured at start) |
| sel_src | output | 2 | Index of the chosen source |
| pre_code | output | 5 | Pre-divider value minus one |
| post_code | output | 2 | Post-divider value minus one |
| rate_out | output | 32 | Achieved output frequency |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No qualifying source, or zero target |

## Verification
The checker compares the reported rate and chosen source against the `target` and `src_valid` ports, not against the copies captured at start. It therefore assumes those ports, and `src_freq`, hold their values from the start pulse until `done`. The stimulus changes them only while the block is idle, with one exception. The test for an ignored start drives a zero target for a single busy cycle and restores the original target well before completion. That pulse cannot trigger the zero-target property, because that property applies only to an idle block.

// File: rtl/divsel_solver.sv
module divsel_solver #(
  parameter int FW       = 32,
  parameter int NSRC     = 4,
  parameter int PRE_SRC  = 3,
  parameter int PRE_MAX  = 32,
  parameter int POST_MAX = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [FW-1:0]             target,
  input  logic [NSRC-1:0][FW-1:0]   src_freq,
  input  logic [NSRC-1:0]           src_valid,
  output logic [$clog2(NSRC)-1:0]   sel_src,
  output logic [$clog2(PRE_MAX)-1:0] pre_code,
  output logic [$clog2(POST_MAX)-1:0] post_code,
  output logic [FW-1:0]             rate_out,
  output logic                      done,
  output logic                      err
);
  localparam int IW     = $clog2(NSRC);
  localparam int PRE_W  = $clog2(PRE_MAX);
  localparam int POST_W = $clog2(POST_MAX);
  localparam int CW     = $clog2(FW);
  localparam int SW     = $clog2(3*PRE_MAX);
  localparam logic [FW-1:0] LIM_PRE  = FW'(PRE_MAX);
  localparam logic [FW-1:0] LIM_POST = FW'(POST_MAX);
  localparam logic [FW-1:0] BAND1    = FW'(PRE_MAX);
  localparam logic [FW-1:0] BAND2    = FW'(2*PRE_MAX);
  localparam logic [FW-1:0] BAND3    = FW'(3*PRE_MAX);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_DIV, S_SPLIT, S_SCALE, S_EVAL, S_NEXT, S_DONE
  } st_t;

  st_t               st;
  logic [IW-1:0]     idx;
  logic [1:0]        phase;
  logic [FW-1:0]     tgt_q;
  logic [NSRC-1:0]   vld_q;
  logic [FW-1:0]     quo, rem, dvs;
  logic [CW-1:0]     cnt;
  logic [PRE_W:0]    pre_v, pre_n;
  logic [POST_W:0]   post_v, post_n;
  logic [FW-1:0]     best_rate;
  logic [IW-1:0]     best_sel;
  logic [PRE_W-1:0]  best_pre;
  logic [POST_W-1:0] best_post;
  logic              found;
  logic              busy;

  logic [FW-1:0]     cur_f, tclamp, ratio, sub, quarter;
  logic [FW:0]       shifted;
  logic              ge;
  logic [PRE_W:0]    half, third;

  assign busy    = (st != S_IDLE);
  assign cur_f   = src_freq[idx];
  assign tclamp  = (tgt_q > cur_f) ? cur_f : tgt_q;

  assign shifted = {rem, quo[FW-1]};
  assign ge      = shifted >= {1'b0, dvs};
  assign sub     = shifted[FW-1:0] - dvs;

  assign ratio   = quo + FW'(rem != '0);
  assign half    = ratio[PRE_W+1:1] + (PRE_W+1)'(ratio[0]);
  assign third   = (PRE_W+1)'(({1'b0, ratio[SW-1:0]} + (SW+1)'(2)) / (SW+1)'(3));
  assign quarter = {2'b0, ratio[FW-1:2]} + FW'(ratio[1:0] != 2'b0);

  always_comb begin
    pre_n  = (PRE_W+1)'(1);
    post_n = (POST_W+1)'(1);
    if (idx == IW'(PRE_SRC) && ratio > LIM_POST) begin
      if (ratio < BAND1) begin
        pre_n  = ratio[PRE_W:0];
      end else if (ratio < BAND2) begin
        pre_n  = half;
        post_n = (POST_W+1)'(2);
      end else if (ratio < BAND3) begin
        pre_n  = third;
        post_n = (POST_W+1)'(3);
      end else begin
        pre_n  = (quarter > LIM_PRE) ? (PRE_W+1)'(PRE_MAX) : quarter[PRE_W:0];
        post_n = (POST_W+1)'(POST_MAX);
      end
    end else begin
      post_n = (ratio > LIM_POST) ? (POST_W+1)'(POST_MAX) : ratio[POST_W:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      phase     <= '0;
      tgt_q     <= '0;
      vld_q     <= '0;
      quo       <= '0;
      rem       <= '0;
      dvs       <= '0;
      cnt       <= '0;
      pre_v     <= '0;
      post_v    <= '0;
      best_rate <= '0;
      best_sel  <= '0;
      best_pre  <= '0;
      best_post <= '0;
      found     <= 1'b0;
      sel_src   <= '0;
      pre_code  <= '0;
      post_code <= '0;
      rate_out  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          if (target == '0) begin
            sel_src   <= '0;
            pre_code  <= '0;
            post_code <= '0;
            rate_out  <= '0;
            err       <= 1'b1;
            done      <= 1'b1;
          end else begin
            tgt_q     <= target;
            vld_q     <= src_valid;
            idx       <= '0;
            best_rate <= '0;
            found     <= 1'b0;
            st        <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (!vld_q[idx] || cur_f == '0) begin
            st <= S_NEXT;
          end else begin
            quo   <= cur_f;
            dvs   <= tclamp;
            rem   <= '0;
            cnt   <= '0;
            phase <= 2'd0;
            st    <= S_DIV;
          end
        end
        S_DIV: begin
          rem <= ge ? sub : shifted[FW-1:0];
          quo <= {quo[FW-2:0], ge};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(FW-1))
            st <= (phase == 2'd0) ? S_SPLIT : (phase == 2'd1) ? S_SCALE : S_EVAL;
        end
        S_SPLIT: begin
          pre_v  <= pre_n;
          post_v <= post_n;
          quo    <= cur_f;
          dvs    <= FW'(pre_n);
          rem    <= '0;
          cnt    <= '0;
          phase  <= 2'd1;
          st     <= S_DIV;
        end
        S_SCALE: begin
          dvs   <= FW'(post_v);
          rem   <= '0;
          cnt   <= '0;
          phase <= 2'd2;
          st    <= S_DIV;
        end
        S_EVAL: begin
          if (quo <= tgt_q && quo > best_rate) begin
            best_rate <= quo;
            best_sel  <= idx;
            best_pre  <= PRE_W'(pre_v - 1'b1);
            best_post <= POST_W'(post_v - 1'b1);
            found     <= 1'b1;
          end
          st <= S_NEXT;
        end
        S_NEXT: begin
          if (idx == IW'(NSRC-1)) begin
            st <= S_DONE;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_LOAD;
          end
        end
        S_DONE: begin
          sel_src   <= found ? best_sel  : '0;
          pre_code  <= found ? best_pre  : '0;
          post_code <= found ? best_post : '0;
          rate_out  <= found ? best_rate : '0;
          err       <= !found;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divsel_solver_chk.sv
module divsel_solver_chk #(
  parameter int FW = 32, NSRC = 4, PRE_SRC = 3, PRE_W = 5, POST_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic [FW-1:0]           target,
  input logic [NSRC-1:0]         src_valid,
  input logic [$clog2(NSRC)-1:0] sel_src,
  input logic [PRE_W-1:0]        pre_code,
  input logic [POST_W-1:0]       post_code,
  input logic [FW-1:0]           rate_out,
  input logic                    done,
  input logic                    err
);
  AST_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && target == '0) |=> (done && err)); // R1
  AST_PRE_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && sel_src != $clog2(NSRC)'(PRE_SRC)) |-> pre_code == '0); // R3
  AST_RATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (rate_out <= target && rate_out != '0)); // R7
  AST_SEL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> src_valid[sel_src]); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rate_out == '0 && sel_src == '0 && pre_code == '0 && post_code == '0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rate_out) && $stable(sel_src) && $stable(err))); // R9
endmodule

bind divsel_solver divsel_solver_chk #(
  .FW(FW), .NSRC(NSRC), .PRE_SRC(PRE_SRC), .PRE_W(PRE_W), .POST_W(POST_W)
) u_chk (.*);

// File: tb/sim_divsel_solver.sv
`timescale 1ns/1ps
module sim_divsel_solver;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [31:0]      target = '0;
  logic [3:0][31:0] src_freq = '0;
  logic [3:0]       src_valid = '0;
  logic [1:0]       sel_src;
  logic [4:0]       pre_code;
  logic [1:0]       post_code;
  logic [31:0]      rate_out;
  logic             done, err;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  divsel_solver u0 (.*);

  typedef struct packed {
    logic [31:0] tgt, s0, s1, s2, s3;
    logic [3:0]  vld;
    logic [1:0]  sel;
    logic [4:0]  pre;
    logic [1:0]  post;
    logic [31:0] rate;
    logic        err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'd100, 32'd300, 32'd250, 32'd400, 32'd0, 4'b0111, 2'd0, 5'd0, 2'd2, 32'd100, 1'b0},
    '{32'd1000, 32'd500, 32'd0, 32'd0, 32'd0, 4'b0001, 2'd0, 5'd0, 2'd0, 32'd500, 1'b0},
    '{32'd10, 32'd0, 32'd0, 32'd0, 32'd200, 4'b1000, 2'd3, 5'd19, 2'd0, 32'd10, 1'b0},
    '{32'd10, 32'd0, 32'd0, 32'd0, 32'd455, 4'b1000, 2'd3, 5'd22, 2'd1, 32'd9, 1'b0},
    '{32'd10, 32'd0, 32'd0, 32'd0, 32'd800, 4'b1000, 2'd3, 5'd26, 2'd2, 32'd9, 1'b0},
    '{32'd10, 32'd0, 32'd0, 32'd0, 32'd1000, 4'b1000, 2'd3, 5'd24, 2'd3, 32'd10, 1'b0},
    '{32'd10, 32'd100, 32'd0, 32'd0, 32'd100, 4'b1001, 2'd3, 5'd9, 2'd0, 32'd10, 1'b0},
    '{32'd1, 32'd100, 32'd0, 32'd0, 32'd100000, 4'b1001, 2'd0, 5'd0, 2'd0, 32'd0, 1'b1},
    '{32'd100, 32'd100, 32'd0, 32'd90, 32'd1000, 4'b0110, 2'd2, 5'd0, 2'd0, 32'd90, 1'b0},
    '{32'd100, 32'd130, 32'd390, 32'd199, 32'd1001, 4'b1111, 2'd2, 5'd0, 2'd1, 32'd99, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, 32'd0, 4'b0011, 2'd0, 5'd0, 2'd0, 32'hFFFFFFFF, 1'b0},
    '{32'd25, 32'd0, 32'd0, 32'd0, 32'd100, 4'b1000, 2'd3, 5'd0, 2'd3, 32'd25, 1'b0},
    '{32'd1, 32'd0, 32'd0, 32'd0, 32'd32, 4'b1000, 2'd3, 5'd15, 2'd1, 32'd1, 1'b0},
    '{32'd1, 32'd0, 32'd0, 32'd0, 32'd96, 4'b1000, 2'd3, 5'd23, 2'd3, 32'd1, 1'b0},
    '{32'd7, 32'd20, 32'd0, 32'd0, 32'd0, 4'b0001, 2'd0, 5'd0, 2'd2, 32'd6, 1'b0},
    '{32'd1, 32'd0, 32'd0, 32'd0, 32'd200, 4'b1000, 2'd3, 5'd31, 2'd3, 32'd1, 1'b0}
  };

  function automatic string tag(input int i);
    case (i)
      0: return "R3";
      1: return "R2";
      2, 3, 4, 5, 11, 12, 13: return "R4";
      6, 15: return "R5";
      7: return "R8";
      8, 9: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic load(input vec_t v);
    target    = v.tgt;
    src_freq  = {v.s3, v.s2, v.s1, v.s0};
    src_valid = v.vld;
  endtask

  task automatic check_result(input string req, input vec_t v);
    chk(req, "sel_src", 32'(sel_src), 32'(v.sel));
    chk(req, "pre_code", 32'(pre_code), 32'(v.pre));
    chk(req, "post_code", 32'(post_code), 32'(v.post));
    chk(req, "rate_out", rate_out, v.rate);
    chk(req, "err", 32'(err), 32'(v.err));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit got;
    logic [31:0] prev_rate;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "done", 32'(done), 32'd0);
    chk("R11", "err", 32'(err), 32'd0);
    chk("R11", "rate_out", rate_out, 32'd0);
    chk("R11", "codes", 32'({sel_src, pre_code, post_code}), 32'd0);

    // R1 zero target
    target = 32'd0; src_freq = {32'd5, 32'd5, 32'd5, 32'd5}; src_valid = 4'hF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "done", 32'(done), 32'd1);
    chk("R1", "err", 32'(err), 32'd1);
    chk("R1", "rate_out", rate_out, 32'd0);
    chk("R1", "codes", 32'({sel_src, pre_code, post_code}), 32'd0);
    @(negedge clk);
    chk("R9", "done pulse", 32'(done), 32'd0);
    prev_rate = 32'd0;

    for (int i = 0; i < NV; i++) begin
      load(VEC[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R9", "held rate", rate_out, prev_rate);
      wait_done(got);
      chk(tag(i), "done seen", 32'(got), 32'd1);
      check_result(tag(i), VEC[i]);
      @(negedge clk);
      chk("R9", "done pulse", 32'(done), 32'd0);
      prev_rate = VEC[i].rate;
    end

    // R10 start while busy is ignored
    load(VEC[9]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    target = 32'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    target = VEC[9].tgt;
    chk("R10", "no early done", 32'(done), 32'd0);
    wait_done(got);
    chk("R10", "done seen", 32'(got), 32'd1);
    check_result("R10", VEC[9]);
    repeat (20) @(negedge clk);
    chk("R10", "no second done", 32'(done), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule